// File: doc/BRIEF.md
# Sharer chain manager

This block keeps track of which caches hold copies of each memory block without a bit vector or a broadcast. For every block, a home register stores just one pointer: the cache at the front of the sharing chain. Each cache tag that holds a copy stores two more pointers, one to the next holder and one to the previous holder, so the holders form a doubly linked chain. Pointer value 0 is the null pointer and marks both the end of a chain and an empty home entry. Node identifiers run from 1 to `NNODE`.

A request names an operation, a node and a block.

- **Read miss:** the new reader is placed at the front of the chain.
- **Write:** the writer walks the chain from the front and sends one invalidation per cycle. It then becomes the only holder.
- **Eviction:** the evicting node unlinks itself by joining its two neighbours.

Every pointer change leaves the block as a message on the message port. The same registered message then updates the tag and home pointer registers inside the block. Only one list-changing operation runs at a time; further requests wait on `req_ready`.

A registered lookup port shows the stored pointers, one cycle after the address is presented. The lookup address is a (node, block) pair.

Top module: `chain_mgr`

## Requirements
- R1: After synchronous reset, every home pointer is 0, no tag is valid, all tag pointers are 0, `req_ready` is 1, and `msg_valid` and `op_done` are 0.
- R2: A read (req_op 0) by a node that holds no copy places that node at the front of the chain.
  - Its next pointer becomes the old front node and its previous pointer becomes 0.
  - The old front node, if there was one, gets the reader as its previous pointer.
  - The home pointer becomes the reader.
  - Exactly 2 messages are sent, or 3 when the chain was not empty.
- R3: A read by a node that already holds a copy changes no pointer and sends no message.
- R4: A write (req_op 1) sends exactly one invalidation message (kind 5) to each holder other than the writer. The invalidations go in chain order starting at the front, at most one per cycle.
- R5: After a write, the writer is the only holder of the block. Its next and previous pointers are 0, and the home pointer is the writer. Exactly two messages follow the invalidations.
- R6: An eviction (req_op 2) by a holder with both neighbours sets the predecessor's next pointer to the successor and the successor's previous pointer to the predecessor. The evicting tag is cleared.
- R7: An eviction by the front holder sets the home pointer to its successor, or to 0 if it has none. The successor's previous pointer becomes 0.
- R8: An eviction by a node that holds no copy changes nothing and sends no message.
- R9: From the cycle after a request is accepted (`req_valid` and `req_ready` both 1) until the operation ends, `req_ready` is 0. Messages appear only while `req_ready` is 0.
- R10: A request with node 0, or with req_op 3, changes nothing and sends no message.
- R11: Each accepted request gives exactly one single-cycle `op_done` pulse. `op_done` is high only while `req_ready` is 0, and `req_ready` returns to 1 in the following cycle.
- R12: Message kinds are encoded as follows:
  - 1: new link. The target becomes valid, next is set to `msg_ptr`, and previous is set to 0.
  - 2: set next pointer.
  - 3: set previous pointer.
  - 4: set home pointer, sent with destination 0.
  - 5: invalidate.
  - All other kinds carry a nonzero destination. No other kind value is ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 ignored |
| req_node | input | PW | Requesting node, 1..NNODE |
| req_blk | input | BW | Memory block index |
| msg_valid | output | 1 | Message present |
| msg_kind | output | 3 | Message kind (R12) |
| msg_dst | output | PW | Target node, 0 for the home |
| msg_blk | output | BW | Block the message concerns |
| msg_ptr | output | PW | Pointer value carried |
| op_done | output | 1 | Operation finished pulse |
| qry_node | input | PW | Lookup node |
| qry_blk | input | BW | Lookup block |
| qry_valid | output | 1 | Tag valid at lookup address (registered) |
| qry_next | output | PW | Tag next pointer (registered) |
| qry_prev | output | PW | Tag previous pointer (registered) |
| qry_head | output | PW | Home pointer of qry_blk (registered) |

## Verification
The bench keeps a pointer model of every chain. It aims at the following corner cases:

- **Evictions at the front, in the middle and at the tail.** Joining the neighbours the wrong way would leave a dangling previous pointer, or a home pointer that still names the evicted node.
- **Writes in three situations:** by a node already in the middle of the chain, by an outsider, and on an empty block. A walk that reads the next pointer after the invalidation has cleared it would stop early. A design that skipped the writer check would send an invalidation to the writer itself. Both show up as a wrong invalidation sequence.
- **Repeated reads by a current holder.** These must not create a self-loop.
- **Requests with node 0 or op code 3.** These must not disturb any stored pointer.

A long mixed sequence over four nodes and four blocks then compares every stored pointer after each operation.

// File: rtl/chain_pkg.sv
package chain_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    MK_IDLE     = 3'd0,
    MK_LINK_NEW = 3'd1,
    MK_SET_NEXT = 3'd2,
    MK_SET_PREV = 3'd3,
    MK_SET_HEAD = 3'd4,
    MK_INVAL    = 3'd5
  } msg_e;

endpackage

// File: rtl/chain_home.sv
module chain_home
  import chain_pkg::*;
#(
  parameter int PW   = 3,
  parameter int BW   = 2,
  parameter int NBLK = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ap_valid,
  input  logic [2:0]    ap_kind,
  input  logic [BW-1:0] ap_blk,
  input  logic [PW-1:0] ap_ptr,
  input  logic [BW-1:0] rd_blk,
  output logic [PW-1:0] rd_head,
  input  logic [BW-1:0] qy_blk,
  output logic [PW-1:0] qy_head
);

  logic [PW-1:0] head [NBLK];

  // One head register per block; only a home-pointer message changes it.
  for (genvar b = 0; b < NBLK; b++) begin : g_head
    always_ff @(posedge clk) begin
      if (rst) begin
        head[b] <= '0;
      end else if (ap_valid && ap_kind == MK_SET_HEAD && ap_blk == BW'(b)) begin
        head[b] <= ap_ptr;
      end
    end
  end

  assign rd_head = head[rd_blk];
  assign qy_head = head[qy_blk];

endmodule

// File: rtl/chain_tags.sv
module chain_tags
  import chain_pkg::*;
#(
  parameter int PW = 3,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ap_valid,
  input  logic [2:0]    ap_kind,
  input  logic [PW-1:0] ap_dst,
  input  logic [BW-1:0] ap_blk,
  input  logic [PW-1:0] ap_ptr,
  input  logic [PW-1:0] rq_node,
  input  logic [BW-1:0] rq_blk,
  output logic          rq_valid,
  output logic [PW-1:0] rq_next,
  output logic [PW-1:0] rq_prev,
  input  logic [PW-1:0] wk_node,
  input  logic [BW-1:0] wk_blk,
  output logic          wk_valid,
  output logic [PW-1:0] wk_next,
  input  logic [PW-1:0] qy_node,
  input  logic [BW-1:0] qy_blk,
  output logic          qy_valid,
  output logic [PW-1:0] qy_next,
  output logic [PW-1:0] qy_prev
);

  localparam int AW  = PW + BW;
  localparam int DEP = 1 << AW;

  logic          tv [DEP];
  logic [PW-1:0] tn [DEP];
  logic [PW-1:0] tp [DEP];

  logic [AW-1:0] wa;
  assign wa = {ap_dst, ap_blk};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEP; i++) begin
        tv[i] <= 1'b0;
        tn[i] <= '0;
        tp[i] <= '0;
      end
    end else if (ap_valid) begin
      case (ap_kind)
        MK_LINK_NEW: begin
          tv[wa] <= 1'b1;
          tn[wa] <= ap_ptr;
          tp[wa] <= '0;
        end
        MK_SET_NEXT: tn[wa] <= ap_ptr;
        MK_SET_PREV: tp[wa] <= ap_ptr;
        MK_INVAL: begin
          tv[wa] <= 1'b0;
          tn[wa] <= '0;
          tp[wa] <= '0;
        end
        default: ;
      endcase
    end
  end

  logic [AW-1:0] ra, ka, qa;
  assign ra = {rq_node, rq_blk};
  assign ka = {wk_node, wk_blk};
  assign qa = {qy_node, qy_blk};

  assign rq_valid = tv[ra];
  assign rq_next  = tn[ra];
  assign rq_prev  = tp[ra];
  assign wk_valid = tv[ka];
  assign wk_next  = tn[ka];
  assign qy_valid = tv[qa];
  assign qy_next  = tn[qa];
  assign qy_prev  = tp[qa];

endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import chain_pkg::*;
#(
  parameter int PW = 3,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  output logic          req_ready,
  input  logic [PW-1:0] head_rd,
  input  logic          rq_valid,
  input  logic [PW-1:0] rq_next,
  input  logic [PW-1:0] rq_prev,
  output logic [PW-1:0] wk_node,
  output logic [BW-1:0] wk_blk,
  input  logic          wk_valid,
  input  logic [PW-1:0] wk_next,
  output logic          m_valid,
  output logic [2:0]    m_kind,
  output logic [PW-1:0] m_dst,
  output logic [BW-1:0] m_blk,
  output logic [PW-1:0] m_ptr,
  output logic          done
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_LINK, S_RD_PREV, S_RD_HEAD,
    S_WR_WALK, S_WR_LINK, S_WR_HEAD,
    S_EV_PRED, S_EV_SUCC, S_EV_DROP, S_FIN
  } st_e;

  st_e           state, state_n;
  logic [PW-1:0] node_q, node_n;
  logic [BW-1:0] blk_q, blk_n;
  logic [PW-1:0] a_q, a_n;   // old front / walk cursor / predecessor
  logic [PW-1:0] b_q, b_n;   // successor during eviction

  logic          e_valid;
  msg_e          e_kind;
  logic [PW-1:0] e_dst, e_ptr;

  assign req_ready = (state == S_IDLE);
  assign wk_node   = a_q;
  assign wk_blk    = blk_q;

  always_comb begin
    state_n = state;
    node_n  = node_q;
    blk_n   = blk_q;
    a_n     = a_q;
    b_n     = b_q;
    e_valid = 1'b0;
    e_kind  = MK_IDLE;
    e_dst   = '0;
    e_ptr   = '0;
    case (state)
      S_IDLE: begin
        if (req_valid) begin
          node_n = req_node;
          blk_n  = req_blk;
          if (req_node == '0 || req_op == OP_NONE) begin
            state_n = S_FIN;
          end else if (req_op == OP_READ) begin
            a_n     = head_rd;
            state_n = rq_valid ? S_FIN : S_RD_LINK;
          end else if (req_op == OP_WRITE) begin
            a_n     = head_rd;
            state_n = S_WR_WALK;
          end else begin
            a_n     = rq_prev;
            b_n     = rq_next;
            state_n = rq_valid ? S_EV_PRED : S_FIN;
          end
        end
      end
      S_RD_LINK: begin
        e_valid = 1'b1;
        e_kind  = MK_LINK_NEW;
        e_dst   = node_q;
        e_ptr   = a_q;
        state_n = (a_q != '0) ? S_RD_PREV : S_RD_HEAD;
      end
      S_RD_PREV: begin
        e_valid = 1'b1;
        e_kind  = MK_SET_PREV;
        e_dst   = a_q;
        e_ptr   = node_q;
        state_n = S_RD_HEAD;
      end
      S_RD_HEAD: begin
        e_valid = 1'b1;
        e_kind  = MK_SET_HEAD;
        e_ptr   = node_q;
        state_n = S_FIN;
      end
      S_WR_WALK: begin
        if (a_q == '0 || !wk_valid) begin
          state_n = S_WR_LINK;
        end else begin
          if (a_q != node_q) begin
            e_valid = 1'b1;
            e_kind  = MK_INVAL;
            e_dst   = a_q;
          end
          a_n = wk_next;
        end
      end
      S_WR_LINK: begin
        e_valid = 1'b1;
        e_kind  = MK_LINK_NEW;
        e_dst   = node_q;
        state_n = S_WR_HEAD;
      end
      S_WR_HEAD: begin
        e_valid = 1'b1;
        e_kind  = MK_SET_HEAD;
        e_ptr   = node_q;
        state_n = S_FIN;
      end
      S_EV_PRED: begin
        e_valid = 1'b1;
        e_ptr   = b_q;
        if (a_q != '0) begin
          e_kind = MK_SET_NEXT;
          e_dst  = a_q;
        end else begin
          e_kind = MK_SET_HEAD;
        end
        state_n = S_EV_SUCC;
      end
      S_EV_SUCC: begin
        if (b_q != '0) begin
          e_valid = 1'b1;
          e_kind  = MK_SET_PREV;
          e_dst   = b_q;
          e_ptr   = a_q;
        end
        state_n = S_EV_DROP;
      end
      S_EV_DROP: begin
        e_valid = 1'b1;
        e_kind  = MK_INVAL;
        e_dst   = node_q;
        state_n = S_FIN;
      end
      S_FIN:   state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      node_q  <= '0;
      blk_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      m_valid <= 1'b0;
      m_kind  <= '0;
      m_dst   <= '0;
      m_blk   <= '0;
      m_ptr   <= '0;
      done    <= 1'b0;
    end else begin
      state   <= state_n;
      node_q  <= node_n;
      blk_q   <= blk_n;
      a_q     <= a_n;
      b_q     <= b_n;
      m_valid <= e_valid;
      m_kind  <= e_kind;
      m_dst   <= e_dst;
      m_blk   <= blk_q;
      m_ptr   <= e_ptr;
      done    <= (state_n == S_FIN);
    end
  end

endmodule

// File: rtl/chain_mgr.sv
module chain_mgr
  import chain_pkg::*;
#(
  parameter int NNODE = 4,
  parameter int NBLK  = 4,
  localparam int PW   = $clog2(NNODE + 1),
  localparam int BW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  output logic          msg_valid,
  output logic [2:0]    msg_kind,
  output logic [PW-1:0] msg_dst,
  output logic [BW-1:0] msg_blk,
  output logic [PW-1:0] msg_ptr,
  output logic          op_done,
  input  logic [PW-1:0] qry_node,
  input  logic [BW-1:0] qry_blk,
  output logic          qry_valid,
  output logic [PW-1:0] qry_next,
  output logic [PW-1:0] qry_prev,
  output logic [PW-1:0] qry_head
);

  logic [PW-1:0] head_rd, qy_head_c;
  logic          rq_valid, wk_valid, qy_valid_c;
  logic [PW-1:0] rq_next, rq_prev, wk_next, qy_next_c, qy_prev_c;
  logic [PW-1:0] wk_node;
  logic [BW-1:0] wk_blk;

  chain_seq #(.PW(PW), .BW(BW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_node (req_node),
    .req_blk  (req_blk),
    .req_ready(req_ready),
    .head_rd  (head_rd),
    .rq_valid (rq_valid),
    .rq_next  (rq_next),
    .rq_prev  (rq_prev),
    .wk_node  (wk_node),
    .wk_blk   (wk_blk),
    .wk_valid (wk_valid),
    .wk_next  (wk_next),
    .m_valid  (msg_valid),
    .m_kind   (msg_kind),
    .m_dst    (msg_dst),
    .m_blk    (msg_blk),
    .m_ptr    (msg_ptr),
    .done     (op_done)
  );

  chain_home #(.PW(PW), .BW(BW), .NBLK(NBLK)) u_home (
    .clk     (clk),
    .rst     (rst),
    .ap_valid(msg_valid),
    .ap_kind (msg_kind),
    .ap_blk  (msg_blk),
    .ap_ptr  (msg_ptr),
    .rd_blk  (req_blk),
    .rd_head (head_rd),
    .qy_blk  (qry_blk),
    .qy_head (qy_head_c)
  );

  chain_tags #(.PW(PW), .BW(BW)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .ap_valid(msg_valid),
    .ap_kind (msg_kind),
    .ap_dst  (msg_dst),
    .ap_blk  (msg_blk),
    .ap_ptr  (msg_ptr),
    .rq_node (req_node),
    .rq_blk  (req_blk),
    .rq_valid(rq_valid),
    .rq_next (rq_next),
    .rq_prev (rq_prev),
    .wk_node (wk_node),
    .wk_blk  (wk_blk),
    .wk_valid(wk_valid),
    .wk_next (wk_next),
    .qy_node (qry_node),
    .qy_blk  (qry_blk),
    .qy_valid(qy_valid_c),
    .qy_next (qy_next_c),
    .qy_prev (qy_prev_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_valid <= 1'b0;
      qry_next  <= '0;
      qry_prev  <= '0;
      qry_head  <= '0;
    end else begin
      qry_valid <= qy_valid_c;
      qry_next  <= qy_next_c;
      qry_prev  <= qy_prev_c;
      qry_head  <= qy_head_c;
    end
  end

endmodule

// File: rtl/chain_mgr_chk.sv
module chain_mgr_chk
  import chain_pkg::*;
#(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          msg_valid,
  input logic [2:0]    msg_kind,
  input logic [PW-1:0] msg_dst,
  input logic          op_done
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_MSG_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !req_ready); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    op_done |-> !req_ready); // R11
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    op_done |=> (req_ready && !op_done)); // R11
  AST_HOME_MSG_DST: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == MK_SET_HEAD) |-> (msg_dst == '0)); // R12
  AST_NODE_MSG_DST: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind != MK_SET_HEAD) |-> (msg_dst != '0)); // R12
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_kind >= MK_LINK_NEW && msg_kind <= MK_INVAL)); // R12

endmodule

bind chain_mgr chain_mgr_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .msg_valid(msg_valid),
  .msg_kind (msg_kind),
  .msg_dst  (msg_dst),
  .op_done  (op_done)
);

// File: tb/sim_chain_mgr.sv
module sim_chain_mgr;
  localparam int NN = 4;
  localparam int NB = 4;
  localparam int PW = 3;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [PW-1:0] req_node = '0;
  logic [BW-1:0] req_blk = '0;
  logic          msg_valid;
  logic [2:0]    msg_kind;
  logic [PW-1:0] msg_dst, msg_ptr;
  logic [BW-1:0] msg_blk;
  logic          op_done;
  logic [PW-1:0] qry_node = '0;
  logic [BW-1:0] qry_blk = '0;
  logic          qry_valid;
  logic [PW-1:0] qry_next, qry_prev, qry_head;

  always #4 clk = ~clk;

  chain_mgr #(.NNODE(NN), .NBLK(NB)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_node(req_node), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .msg_blk(msg_blk), .msg_ptr(msg_ptr), .op_done(op_done),
    .qry_node(qry_node), .qry_blk(qry_blk), .qry_valid(qry_valid),
    .qry_next(qry_next), .qry_prev(qry_prev), .qry_head(qry_head)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Pointer model, index 0 unused (null)
  int m_valid [0:NN][0:NB-1];
  int m_next  [0:NN][0:NB-1];
  int m_prev  [0:NN][0:NB-1];
  int m_head  [0:NB-1];

  // Message monitor: only ever counts up
  int mon_cnt = 0;
  int mon_bad = 0;
  int mon_inv_tot = 0;
  int mon_inv [0:255];

  always @(negedge clk) begin
    if (!rst && msg_valid) begin
      mon_cnt++;
      if (msg_kind == 3'd5) begin
        mon_inv[mon_inv_tot % 256] = int'(msg_dst);
        mon_inv_tot++;
      end
      if (msg_kind == 3'd0 || msg_kind > 3'd5 || (msg_kind == 3'd4 && msg_dst != '0) ||
          (msg_kind != 3'd4 && msg_dst == '0))
        mon_bad++;
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic sweep(input string r);
    int bad = 0;
    for (int b = 0; b < NB; b++) begin
      for (int n = 1; n <= NN; n++) begin
        qry_node = PW'(n);
        qry_blk  = BW'(b);
        @(negedge clk);
        if (int'(qry_valid) != m_valid[n][b] || int'(qry_next) != m_next[n][b] ||
            int'(qry_prev) != m_prev[n][b] || int'(qry_head) != m_head[b]) begin
          if (bad == 0)
            $display("FAIL %s pointers node %0d blk %0d: got v%0d n%0d p%0d h%0d expected v%0d n%0d p%0d h%0d",
                     r, n, b, qry_valid, qry_next, qry_prev, qry_head,
                     m_valid[n][b], m_next[n][b], m_prev[n][b], m_head[b]);
          bad++;
        end
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
  endtask

  task automatic do_op(input int op, input int node, input int blk, input string r);
    int exp_cnt = 0;
    int exp_inv [0:15];
    int exp_ninv = 0;
    int base_cnt, base_inv, base_bad, guard;
    // Expected outcome from the requirements
    if (node != 0 && op != 3) begin
      if (op == 0) begin
        if (m_valid[node][blk] == 0) begin
          int old = m_head[blk];
          m_valid[node][blk] = 1;
          m_next[node][blk]  = old;
          m_prev[node][blk]  = 0;
          if (old != 0) m_prev[old][blk] = node;
          m_head[blk] = node;
          exp_cnt = (old != 0) ? 3 : 2;
        end
      end else if (op == 1) begin
        int cur = m_head[blk];
        for (int s = 0; s < NN && cur != 0; s++) begin
          if (cur != node) begin
            exp_inv[exp_ninv] = cur;
            exp_ninv++;
          end
          cur = m_next[cur][blk];
        end
        for (int n = 1; n <= NN; n++) begin
          m_valid[n][blk] = 0; m_next[n][blk] = 0; m_prev[n][blk] = 0;
        end
        m_valid[node][blk] = 1;
        m_head[blk] = node;
        exp_cnt = exp_ninv + 2;
      end else if (m_valid[node][blk] != 0) begin
        int p = m_prev[node][blk];
        int nx = m_next[node][blk];
        if (p != 0) m_next[p][blk] = nx; else m_head[blk] = nx;
        if (nx != 0) m_prev[nx][blk] = p;
        m_valid[node][blk] = 0; m_next[node][blk] = 0; m_prev[node][blk] = 0;
        exp_cnt = (nx != 0) ? 3 : 2;
        exp_inv[0] = node;
        exp_ninv = 1;
      end
    end
    base_cnt = mon_cnt;
    base_inv = mon_inv_tot;
    base_bad = mon_bad;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_node  = PW'(node);
    req_blk   = BW'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready after accept", int'(req_ready), 0);
    guard = 0;
    while (!op_done && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(op_done == 1'b0 && req_ready == 1'b1, "R11", "done single pulse then ready",
        int'({op_done, req_ready}), 1);
    chk(mon_cnt - base_cnt == exp_cnt, r, "message count", mon_cnt - base_cnt, exp_cnt);
    chk(mon_inv_tot - base_inv == exp_ninv, r, "invalidation count", mon_inv_tot - base_inv, exp_ninv);
    if (mon_inv_tot - base_inv == exp_ninv) begin
      for (int i = 0; i < exp_ninv; i++)
        chk(mon_inv[(base_inv + i) % 256] == exp_inv[i], r, "invalidation order",
            mon_inv[(base_inv + i) % 256], exp_inv[i]);
    end
    chk(mon_bad == base_bad, "R12", "message encoding", mon_bad - base_bad, 0);
    sweep(r);
  endtask

  task automatic run_all();
    bit [31:0] s = 32'h1234_5678;
    for (int n = 0; n <= NN; n++)
      for (int b = 0; b < NB; b++) begin
        m_valid[n][b] = 0; m_next[n][b] = 0; m_prev[n][b] = 0;
      end
    for (int b = 0; b < NB; b++) m_head[b] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && msg_valid == 1'b0 && op_done == 1'b0, "R1", "idle outputs after reset",
        int'({req_ready, msg_valid, op_done}), 4);
    sweep("R1");
    // Directed: build, reread, unlink in middle and at front, stray eviction
    do_op(0, 1, 0, "R2");
    do_op(0, 2, 0, "R2");
    do_op(0, 3, 0, "R2");
    do_op(0, 2, 0, "R3");
    do_op(2, 2, 0, "R6");
    do_op(2, 3, 0, "R7");
    do_op(2, 2, 0, "R8");
    do_op(2, 1, 0, "R7");
    // Write by a node in the middle of a four-long chain
    for (int n = 1; n <= NN; n++) do_op(0, n, 1, "R2");
    do_op(1, 3, 1, "R4");
    sweep("R5");
    // Write on an empty block and by an outsider
    do_op(1, 2, 2, "R5");
    do_op(0, 1, 3, "R2");
    do_op(0, 4, 3, "R2");
    do_op(1, 2, 3, "R4");
    // Ignored requests
    do_op(0, 0, 3, "R10");
    do_op(1, 0, 3, "R10");
    do_op(3, 1, 3, "R10");
    // Mixed sweep over all nodes and blocks
    for (int k = 0; k < 300; k++) begin
      int op, nd, bk;
      string r;
      s = s * 32'd1103515245 + 32'd12345;
      op = (s[19:16] < 4'd8) ? 0 : (s[19:16] < 4'd11) ? 1 : 2;
      nd = int'(s[25:24]) + 1;
      bk = int'(s[29:28]);
      if (op == 0) r = (m_valid[nd][bk] != 0) ? "R3" : "R2";
      else if (op == 1) r = "R4";
      else if (m_valid[nd][bk] == 0) r = "R8";
      else r = (m_prev[nd][bk] != 0) ? "R6" : "R7";
      do_op(op, nd, bk, r);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d cycles", 150000, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule